// File: doc/BRIEF.md
# Programmable Sync Word Detector

This block watches a received serial bit stream in which each bit arrives with a one-cycle valid strobe. It searches for a synchronization character and reports it with a single-cycle pulse. The character is either one byte long or a full 16-bit word. In word form the upper byte is fixed at 2Dh and must arrive first, followed by the lower byte. The lower byte is held in a small configuration register, and a mode bit there chooses between byte and word matching.

Once the character has been found, the detector stops searching. It then gathers every following group of eight bits into a byte, which it hands to a downstream FIFO with a one-cycle write strobe. This continues until the detector is re-armed. Re-arming empties the shift register and starts a new search from nothing. Bit-clock recovery, FIFO storage and any framing after the sync character belong to other blocks.

Top module: `sync_word_detector`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `sync_hit`, `locked` and `byte_we` are 0. The programmable byte is D4h and word mode is selected (`RESET_WIDE`=1).
- R2: In word mode, bits are shifted in MSB first on each strobe. `sync_hit` is 1 for exactly one cycle, in the cycle after the edge that accepts the last bit, when the latest 16 accepted bits equal {2Dh, programmable byte}. A wrong first byte gives no pulse.
- R3: In byte mode (`cfg_wide`=0), only the latest 8 accepted bits are compared, against the programmable byte alone.
- R4: When `cfg_we` is high at an edge, `cfg_lo` and `cfg_wide` are loaded. Otherwise the configuration holds its value.
- R5: A match counts only once at least 8 bits (byte mode) or 16 bits (word mode) have been accepted since reset or the last re-arm.
- R6: A pulse on `sync_hit` sets `locked`. While `locked` is 1, no further `sync_hit` pulse occurs until a re-arm.
- R7: While `locked` is 1, each group of 8 accepted bits is packed MSB first into `byte_out`. `byte_we` is 1 for one cycle, in the cycle after the edge that accepts the eighth bit.
- R8: `rearm` high at an edge clears `locked`, the shift register, the bit count and any partial byte. A bit strobed in the same cycle is dropped.
- R9: `bit_in` has no effect in cycles where `bit_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | Bit valid strobe |
| rearm | input | 1 | Restart the sync search |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wide | input | 1 | 1 = word match, 0 = byte match |
| cfg_lo | input | 8 | Programmable low sync byte |
| sync_hit | output | 1 | Sync found pulse |
| locked | output | 1 | Sync found, passing data |
| byte_out | output | 8 | Assembled data byte |
| byte_we | output | 1 | Write strobe for `byte_out` |

## Verification
A bit slip in the shift register moves the `sync_hit` pulse by at least one strobe from the expected bit position, or removes it entirely. The stimulus table checks the pulse position on every bit. A bad bit count shows in one of two ways: a pulse arrives too early after a re-arm, or the `byte_we` strobes fall out of line with the 8-bit groups that follow the sync character. Either appears within eight strobes. A stuck lock state shows as a missing or repeated pulse in the first search after a re-arm.

// File: rtl/sdet_pkg.sv
package sdet_pkg;
  localparam int unsigned SYNC_BYTE_W = 8;
  localparam int unsigned SYNC_WORD_W = 2 * SYNC_BYTE_W;
  localparam int unsigned FILL_W      = $clog2(SYNC_WORD_W + 1);

  typedef logic [SYNC_BYTE_W-1:0] sbyte_t;
  typedef logic [SYNC_WORD_W-1:0] sword_t;
  typedef logic [FILL_W-1:0]      fill_t;

  localparam fill_t FILL_BYTE = fill_t'(SYNC_BYTE_W);
  localparam fill_t FILL_WORD = fill_t'(SYNC_WORD_W);

  typedef struct packed {
    logic   wide;
    sbyte_t lo;
  } sync_cfg_t;

  // next window after one MSB-first bit
  function automatic sword_t push_bit(sword_t w, logic b);
    return {w[SYNC_WORD_W-2:0], b};
  endfunction

  // saturating count of accepted bits
  function automatic fill_t fill_step(fill_t f);
    return (f >= FILL_WORD) ? FILL_WORD : f + fill_t'(1);
  endfunction

  function automatic logic sync_match(sword_t w, fill_t f, sbyte_t hi, sync_cfg_t c);
    if (c.wide) return (f >= FILL_WORD) && (w == {hi, c.lo});
    else        return (f >= FILL_BYTE) && (w[SYNC_BYTE_W-1:0] == c.lo);
  endfunction
endpackage

// File: rtl/sdet_cfg_reg.sv
module sdet_cfg_reg
  import sdet_pkg::*;
#(
  parameter sbyte_t RESET_LO   = 8'hD4,
  parameter bit     RESET_WIDE = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  sync_cfg_t wdata,
  output sync_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.lo   <= RESET_LO;
      cfg.wide <= RESET_WIDE;
    end else if (we) begin
      cfg <= wdata;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg)); // R4
endmodule

// File: rtl/sdet_shifter.sv
module sdet_shifter
  import sdet_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clear,
  input  logic   shift_en,
  input  logic   bit_in,
  output sword_t win_next,
  output fill_t  fill_next,
  output fill_t  fill_q
);
  sword_t win_q;

  assign win_next  = push_bit(win_q, bit_in);
  assign fill_next = fill_step(fill_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      win_q  <= win_next;
      fill_q <= fill_next;
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear |=> (fill_q == '0)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !clear) |=> ($stable(win_q) && $stable(fill_q))); // R9
endmodule

// File: rtl/sdet_matcher.sv
module sdet_matcher
  import sdet_pkg::*;
#(
  parameter sbyte_t FIXED_HI = 8'h2D
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clear,
  input  logic      shift_en,
  input  sword_t    win_next,
  input  fill_t     fill_next,
  input  sync_cfg_t cfg,
  output logic      hit_q,
  output logic      locked_q
);
  logic found;

  assign found = shift_en && !locked_q && sync_match(win_next, fill_next, FIXED_HI, cfg);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hit_q    <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      hit_q <= found;
      if (found) locked_q <= 1'b1;
    end
  end

  AST_HIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    hit_q |=> !hit_q); // R2
  AST_LOCK_FROM_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_q) |-> hit_q); // R6
  AST_NO_HIT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !clear) |=> !hit_q); // R6
endmodule

// File: rtl/sdet_byte_packer.sv
module sdet_byte_packer
  import sdet_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clear,
  input  logic   shift_en,
  input  logic   active,
  input  logic   bit_in,
  output sbyte_t byte_q,
  output logic   we_q
);
  localparam int unsigned CNT_W = $clog2(SYNC_BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_BYTE_W - 1);

  logic [CNT_W-1:0] cnt_q;
  sbyte_t           acc_q;
  sbyte_t           acc_next;

  assign acc_next = {acc_q[SYNC_BYTE_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      byte_q <= '0;
      we_q   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (shift_en && active) begin
        acc_q <= acc_next;
        if (cnt_q == CNT_LAST) begin
          cnt_q  <= '0;
          byte_q <= acc_next;
          we_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_WE_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
    we_q |-> $past(shift_en && active)); // R7
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    we_q |=> !we_q); // R7
endmodule

// File: rtl/sync_word_detector.sv
module sync_word_detector
  import sdet_pkg::*;
#(
  parameter sbyte_t FIXED_HI   = 8'h2D,
  parameter sbyte_t RESET_LO   = 8'hD4,
  parameter bit     RESET_WIDE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_in,
  input  logic       bit_vld,
  input  logic       rearm,
  input  logic       cfg_we,
  input  logic       cfg_wide,
  input  logic [7:0] cfg_lo,
  output logic       sync_hit,
  output logic       locked,
  output logic [7:0] byte_out,
  output logic       byte_we
);
  sync_cfg_t cfg, cfg_wdata;
  sword_t    win_next;
  fill_t     fill_next, fill_q;
  logic      shift_en;

  // re-arm wins over a bit in the same cycle
  assign shift_en  = bit_vld && !rearm;
  assign cfg_wdata = '{wide: cfg_wide, lo: cfg_lo};

  sdet_cfg_reg #(.RESET_LO(RESET_LO), .RESET_WIDE(RESET_WIDE)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg));

  sdet_shifter u_shift (
    .clk(clk), .rst(rst), .clear(rearm), .shift_en(shift_en), .bit_in(bit_in),
    .win_next(win_next), .fill_next(fill_next), .fill_q(fill_q));

  sdet_matcher #(.FIXED_HI(FIXED_HI)) u_match (
    .clk(clk), .rst(rst), .clear(rearm), .shift_en(shift_en),
    .win_next(win_next), .fill_next(fill_next), .cfg(cfg),
    .hit_q(sync_hit), .locked_q(locked));

  sdet_byte_packer u_pack (
    .clk(clk), .rst(rst), .clear(rearm), .shift_en(shift_en), .active(locked),
    .bit_in(bit_in), .byte_q(byte_out), .we_q(byte_we));

  AST_HIT_HAS_FILL: assert property (@(posedge clk) disable iff (rst)
    sync_hit |-> (fill_q >= FILL_BYTE)); // R5
  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    sync_hit |-> $past(bit_vld)); // R9
endmodule

// File: tb/sync_word_detector_test.sv
module sync_word_detector_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic        wide;
    logic [7:0]  lo;
    logic [31:0] data;
    logic [5:0]  pos;   // bit count at which the pulse appears, 0 = none
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 8'hD4, 32'h2DD4A5C3, 6'd16},
    '{1'b1, 8'hD4, 32'h02DD4000, 6'd20},
    '{1'b1, 8'hD4, 32'hFFD4FFFF, 6'd0},
    '{1'b0, 8'h5A, 32'h005A0000, 6'd16},
    '{1'b0, 8'h00, 32'h00FFFFFF, 6'd8},
    '{1'b1, 8'h00, 32'h2D00FFFF, 6'd16},
    '{1'b1, 8'hA7, 32'hA72DA7FF, 6'd24},
    '{1'b0, 8'h2D, 32'h12D00000, 6'd12}
  };

  logic clk = 0, rst = 1, bit_in = 0, bit_vld = 0, rearm = 0;
  logic cfg_we = 0, cfg_wide = 0;
  logic [7:0] cfg_lo = 0;
  logic sync_hit, locked, byte_we;
  logic [7:0] byte_out;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_word_detector uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .rearm(rearm),
    .cfg_we(cfg_we), .cfg_wide(cfg_wide), .cfg_lo(cfg_lo),
    .sync_hit(sync_hit), .locked(locked), .byte_out(byte_out), .byte_we(byte_we));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one strobed bit, then an idle cycle with the opposite bit level
  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_vld = 1;
    @(negedge clk); bit_vld = 0; bit_in = ~b;
  endtask

  task automatic do_rearm();
    @(negedge clk); rearm = 1;
    @(negedge clk); rearm = 0;
  endtask

  task automatic write_cfg(input logic w, input logic [7:0] lo);
    @(negedge clk); cfg_we = 1; cfg_wide = w; cfg_lo = lo;
    @(negedge clk); cfg_we = 0; cfg_wide = ~w; cfg_lo = ~lo;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!sync_hit, "R1 sync_hit", sync_hit, 0);
    check(!locked,   "R1 locked",   locked, 0);
    check(!byte_we,  "R1 byte_we",  byte_we, 0);
    // R1 default word D4: 2DD4 found with no config write
    for (int k = 31; k >= 16; k--) send_bit(32'h2DD40000 >> k);
    check(sync_hit, "R1 default pattern", sync_hit, 1);

    // table walk: R2 word mode, R3 byte mode, R4 config, R7 data bytes
    for (int v = 0; v < 8; v++) begin
      do_rearm();
      write_cfg(VECS[v].wide, VECS[v].lo);
      for (int k = 1; k <= 32; k++) begin
        logic expect_we;
        send_bit(VECS[v].data[32-k]);
        check(sync_hit == (k == VECS[v].pos),
              VECS[v].wide ? "R2 word sync_hit" : "R3 byte sync_hit",
              sync_hit, (k == VECS[v].pos));
        expect_we = (VECS[v].pos != 0) && (k > VECS[v].pos) && (((k - VECS[v].pos) % 8) == 0);
        check(byte_we == expect_we, "R7 byte_we", byte_we, expect_we);
        if (expect_we)
          check(byte_out == VECS[v].data[32-k +: 8], "R7 byte_out", byte_out, VECS[v].data[32-k +: 8]);
      end
      check(locked == (VECS[v].pos != 0), "R6 locked at vector end", locked, (VECS[v].pos != 0));
    end

    // R6: no second pulse while locked
    do_rearm();
    write_cfg(1'b1, 8'hD4);
    for (int k = 15; k >= 0; k--) send_bit(16'h2DD4 >> k);
    check(sync_hit, "R2 directed word hit", sync_hit, 1);
    for (int k = 15; k >= 0; k--) begin
      send_bit(16'h2DD4 >> k);
      check(!sync_hit, "R6 no pulse while locked", sync_hit, 0);
    end
    check(locked, "R6 stays locked", locked, 1);

    // R8: re-arm with a simultaneous bit drops the bit
    write_cfg(1'b0, 8'hFF);
    @(negedge clk); rearm = 1; bit_vld = 1; bit_in = 1;
    @(negedge clk); rearm = 0; bit_vld = 0; bit_in = 0;
    check(!locked, "R8 unlocked", locked, 0);
    for (int k = 1; k <= 7; k++) begin
      send_bit(1'b1);
      check(!sync_hit, "R8 dropped bit not counted", sync_hit, 0);
    end
    send_bit(1'b1);
    check(sync_hit, "R8 hit on eighth bit", sync_hit, 1);

    // R9: bit_in toggling without strobe is ignored
    do_rearm();
    for (int k = 1; k <= 7; k++) send_bit(1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); bit_in = k[0];
      check(!sync_hit, "R9 unstrobed bit", sync_hit, 0);
    end
    send_bit(1'b1);
    check(sync_hit, "R9 hit after strobe", sync_hit, 1);

    // R5: byte 00 needs eight bits after re-arm
    write_cfg(1'b0, 8'h00);
    do_rearm();
    for (int k = 1; k <= 7; k++) begin
      send_bit(1'b0);
      check(!sync_hit, "R5 too few bits", sync_hit, 0);
    end
    send_bit(1'b0);
    check(sync_hit, "R5 hit at eight bits", sync_hit, 1);

    // R1: reset returns to word D4 and unlocked
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check(!locked && !sync_hit && !byte_we, "R1 after second reset", locked, 0);
    for (int k = 15; k >= 0; k--) send_bit(16'h2DD4 >> k);
    check(sync_hit, "R1 reset restores D4 word", sync_hit, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule